// File: doc/BRIEF.md
# Multi-Mode Operand Fetch Unit

This unit resolves the operand of an already decoded instruction. It takes a 4-bit mode code, an address field, a register selector, an indirection depth and the current program counter. It forms the effective address from them and then issues as many dependent reads as the mode needs on a single-port memory port that answers one cycle after a request. Memory reads fetch both pointer words and the final operand. The unit has a small register file of its own. The register file is loaded through a write port while the unit is idle. The unit increments a register by one itself in the post-increment indexed mode.

A fetch begins with a one-cycle `start` pulse while the unit is idle. The unit ends each fetch with a one-cycle `done` pulse. During that pulse `eff_addr` and `operand` hold the result, and `illegal` flags an unused mode code. The outputs keep their values until the next fetch completes.

Top module: `operand_fetch`

## Requirements
- R1: Mode 0 (immediate) gives operand = eff_addr = A and makes no memory request.
- R2: Mode 1 (direct) reads memory once at A. The effective address is A and the operand is the word read.
- R3: Mode 2 (indirect) reads a pointer at A, then re-reads at each returned word, for `ind_levels` pointer reads in total (a value of 0 counts as 1). The last pointer is the effective address, and one further read returns the operand.
- R4: Mode 3 (register) gives operand = register[R] and eff_addr = R zero-extended, with no memory request.
- R5: Mode 4 (register indirect) reads once at register[R], which is the effective address.
- R6: Mode 5 uses A + register[R] and mode 6 uses A + pc as the effective address, with one read. Sums wrap modulo 2^16.
- R7: Mode 7 (indexed) reads once at A + register[R] and then increments register[R] by one, wrapping modulo 2^16.
- R8: Mode 8 (preindexed indirect) reads a pointer at A + register[R]. The pointer is the effective address, and a second read returns the operand.
- R9: Mode 9 (postindexed indirect) reads a pointer at A. The effective address is that pointer + register[R], and a second read returns the operand.
- R10: `mem_req` is high for one cycle per read. A new request is issued only after `mem_valid` has returned the previous one. Data is taken in the cycle `mem_valid` is high.
- R11: `done` is high for exactly one cycle per accepted start. In modes 0 and 3 and for illegal codes it rises in the cycle after `start`. A `start` pulse while busy is ignored.
- R12: Codes 10 to 15 make no memory request. They finish in the cycle after start with `illegal` high together with `done`, eff_addr = A and operand = 0.
- R13: A register-file write on `rf_we` takes effect only while the unit is idle. A write while a fetch is in progress is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a fetch (idle only) |
| mode | input | 4 | Addressing mode code |
| addr_a | input | 16 | Address field A |
| reg_sel | input | 3 | Register selector R |
| pc | input | 16 | Current program counter |
| ind_levels | input | 2 | Pointer reads for mode 2 (0 acts as 1) |
| rf_we | input | 1 | Register-file load strobe |
| rf_wsel | input | 3 | Register to load |
| rf_wdata | input | 16 | Load value |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 16 | Memory read data |
| mem_valid | input | 1 | Read data valid |
| done | output | 1 | Fetch complete, one cycle |
| eff_addr | output | 16 | Effective address |
| operand | output | 16 | Fetched operand |
| illegal | output | 1 | Unused mode code, with done |

## Verification
The bench targets the depth of chained reads in indirect mode at every level setting. A design that miscounts levels would return a pointer in place of the operand, or issue one request too many or too few. It checks that sums wrap near 0xFFFF, since a carry kept past bit 15 would yield a wrong address. It repeats indexed fetches on one register and reads that register back, which exposes a missing or doubled increment. It also fires start pulses and register writes in the middle of a long fetch. A unit that did not ignore them would restart, corrupt the result or alter a register.

// File: rtl/operand_fetch.sv
module operand_fetch #(
  parameter int W    = 16,
  parameter int NREG = 8,
  localparam int RS  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [3:0]    mode,
  input  logic [W-1:0]  addr_a,
  input  logic [RS-1:0] reg_sel,
  input  logic [W-1:0]  pc,
  input  logic [1:0]    ind_levels,
  input  logic          rf_we,
  input  logic [RS-1:0] rf_wsel,
  input  logic [W-1:0]  rf_wdata,
  output logic          mem_req,
  output logic [W-1:0]  mem_addr,
  input  logic [W-1:0]  mem_rdata,
  input  logic          mem_valid,
  output logic          done,
  output logic [W-1:0]  eff_addr,
  output logic [W-1:0]  operand,
  output logic          illegal
);
  localparam logic [3:0] M_IMM = 4'd0, M_DIR = 4'd1, M_IND = 4'd2, M_REG = 4'd3,
                         M_RIN = 4'd4, M_DSP = 4'd5, M_PCR = 4'd6, M_IDX = 4'd7,
                         M_PRE = 4'd8, M_PST = 4'd9;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_DONE} state_t;

  state_t        st;
  logic [W-1:0]  rf [NREG];
  logic [W-1:0]  cur, xreg, eff_q, opnd_q;
  logic [1:0]    ptr_left;
  logic          post_add, inc_en, ill_q;
  logic [RS-1:0] inc_sel;

  assign mem_req  = (st == S_REQ);
  assign mem_addr = cur;
  assign done     = (st == S_DONE);
  assign illegal  = done & ill_q;
  assign eff_addr = eff_q;
  assign operand  = opnd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cur      <= '0;
      xreg     <= '0;
      eff_q    <= '0;
      opnd_q   <= '0;
      ptr_left <= '0;
      post_add <= 1'b0;
      inc_en   <= 1'b0;
      ill_q    <= 1'b0;
      inc_sel  <= '0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (rf_we) rf[rf_wsel] <= rf_wdata;
          if (start) begin
            ill_q    <= 1'b0;
            post_add <= 1'b0;
            inc_en   <= 1'b0;
            ptr_left <= '0;
            inc_sel  <= reg_sel;
            xreg     <= rf[reg_sel];
            st       <= S_REQ;
            case (mode)
              M_IMM: begin eff_q <= addr_a; opnd_q <= addr_a; st <= S_DONE; end
              M_DIR: cur <= addr_a;
              M_IND: begin
                cur      <= addr_a;
                ptr_left <= (ind_levels == 2'd0) ? 2'd1 : ind_levels;
              end
              M_REG: begin eff_q <= W'(reg_sel); opnd_q <= rf[reg_sel]; st <= S_DONE; end
              M_RIN: cur <= rf[reg_sel];
              M_DSP: cur <= addr_a + rf[reg_sel];
              M_PCR: cur <= addr_a + pc;
              M_IDX: begin cur <= addr_a + rf[reg_sel]; inc_en <= 1'b1; end
              M_PRE: begin cur <= addr_a + rf[reg_sel]; ptr_left <= 2'd1; end
              M_PST: begin cur <= addr_a; ptr_left <= 2'd1; post_add <= 1'b1; end
              default: begin eff_q <= addr_a; opnd_q <= '0; ill_q <= 1'b1; st <= S_DONE; end
            endcase
          end
        end
        S_REQ: st <= S_WAIT;
        S_WAIT: begin
          if (mem_valid) begin
            if (ptr_left != 2'd0) begin
              cur      <= mem_rdata + (post_add ? xreg : '0);
              ptr_left <= ptr_left - 2'd1;
              st       <= S_REQ;
            end else begin
              eff_q  <= cur;
              opnd_q <= mem_rdata;
              if (inc_en) rf[inc_sel] <= rf[inc_sel] + 1'b1;
              st     <= S_DONE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_imm_fast_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start && mode == M_IMM) |=> (done && !mem_req && operand == $past(addr_a)));

  p_reg_fast_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start && mode == M_REG) |=> (done && !mem_req));

  p_single_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  p_wait_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && !mem_valid) |=> !mem_req);

  p_illegal_code_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start && mode > M_PST) |=> (done && illegal && !mem_req));
endmodule

// File: tb/test_operand_fetch.sv
module test_operand_fetch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [15:0] addr_a = '0, pc = '0, rf_wdata = '0, mem_rdata = '0;
  logic [2:0]  reg_sel = '0, rf_wsel = '0;
  logic [1:0]  ind_levels = '0;
  logic        rf_we = 1'b0, mem_valid = 1'b0;
  logic        mem_req, done, illegal;
  logic [15:0] mem_addr, eff_addr, operand;

  int checks = 0, failures = 0, cyc = 0;
  logic [15:0] rf_m [8];

  operand_fetch i_operand_fetch (
    .clk, .rst_n, .start, .mode, .addr_a, .reg_sel, .pc, .ind_levels,
    .rf_we, .rf_wsel, .rf_wdata, .mem_req, .mem_addr, .mem_rdata, .mem_valid,
    .done, .eff_addr, .operand, .illegal);

  always #10 clk = ~clk;

  function automatic logic [15:0] memf(logic [15:0] a);
    logic [15:0] p;
    p = a * 16'h2F1B;
    return p ^ 16'hC3A5;
  endfunction

  always @(posedge clk) begin
    mem_valid <= mem_req;
    mem_rdata <= memf(mem_addr);
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog act=%0d exp=<150000 cycles", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(logic [3:0] m);
    case (m)
      4'd0: return "R1"; 4'd1: return "R2"; 4'd2: return "R3"; 4'd3: return "R4";
      4'd4: return "R5"; 4'd5, 4'd6: return "R6"; 4'd7: return "R7";
      4'd8: return "R8"; 4'd9: return "R9"; default: return "R12";
    endcase
  endfunction

  task automatic load_reg(input logic [2:0] r, input logic [15:0] v);
    @(negedge clk);
    rf_we = 1'b1; rf_wsel = r; rf_wdata = v;
    @(negedge clk);
    rf_we = 1'b0;
    rf_m[r] = v;
  endtask

  task automatic run(input logic [3:0] m, input logic [15:0] a, input logic [2:0] r,
                     input logic [15:0] p, input logic [1:0] lv, input bit poke);
    logic [15:0] e_eff, e_op, q;
    int e_reads, reads, cycles, n;
    bit e_ill;
    string t;
    t = tag_of(m);
    e_ill = 1'b0;
    e_op = '0;
    case (m)
      4'd0: begin e_eff = a; e_op = a; e_reads = 0; end
      4'd1: begin e_eff = a; e_reads = 1; end
      4'd2: begin
        n = (lv == 0) ? 1 : int'(lv);
        q = a;
        for (int k = 0; k < n; k++) q = memf(q);
        e_eff = q; e_reads = n + 1;
      end
      4'd3: begin e_eff = 16'(r); e_op = rf_m[r]; e_reads = 0; end
      4'd4: begin e_eff = rf_m[r]; e_reads = 1; end
      4'd5: begin e_eff = a + rf_m[r]; e_reads = 1; end
      4'd6: begin e_eff = a + p; e_reads = 1; end
      4'd7: begin e_eff = a + rf_m[r]; e_reads = 1; end
      4'd8: begin e_eff = memf(a + rf_m[r]); e_reads = 2; end
      4'd9: begin e_eff = memf(a) + rf_m[r]; e_reads = 2; end
      default: begin e_eff = a; e_reads = 0; e_ill = 1'b1; end
    endcase
    if (m != 4'd0 && m != 4'd3 && !e_ill) e_op = memf(e_eff);
    if (m == 4'd7) rf_m[r] = rf_m[r] + 16'd1;

    @(negedge clk);
    start = 1'b1; mode = m; addr_a = a; reg_sel = r; pc = p; ind_levels = lv;
    @(negedge clk);
    start = 1'b0;
    cycles = 1; reads = 0;
    while (!done && cycles < 40) begin
      if (mem_req) reads++;
      if (poke && cycles == 2) begin
        start = 1'b1; mode = 4'd0; addr_a = 16'h1234;
        rf_we = 1'b1; rf_wsel = r; rf_wdata = 16'hDEAD;
      end else begin
        start = 1'b0; rf_we = 1'b0;
      end
      @(negedge clk);
      cycles++;
    end
    start = 1'b0; rf_we = 1'b0;
    check(done == 1'b1, {t, " done seen"}, 16'(done), 16'd1);
    check(eff_addr == e_eff, {t, " eff_addr"}, eff_addr, e_eff);
    check(operand == e_op, {t, " operand"}, operand, e_op);
    check(illegal == e_ill, {t, " R12 illegal flag"}, 16'(illegal), 16'(e_ill));
    check(reads == e_reads, {t, " R10 read count"}, 16'(reads), 16'(e_reads));
    if (m == 4'd0 || m == 4'd3 || e_ill)
      check(cycles == 1, {t, " R11 done latency"}, 16'(cycles), 16'd1);
    @(negedge clk);
    check(done == 1'b0, {t, " R11 done one cycle"}, 16'(done), 16'd0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 8; i++) rf_m[i] = '0;
    repeat (3) @(negedge clk);
    check(done == 1'b0, "reset done", 16'(done), 16'd0);
    check(mem_req == 1'b0, "reset R10 mem_req", 16'(mem_req), 16'd0);
    check(illegal == 1'b0, "reset R12 illegal", 16'(illegal), 16'd0);
    rst_n = 1'b1;

    for (int i = 0; i < 8; i++) load_reg(3'(i), 16'($urandom));
    run(4'd3, 16'h0, 3'd5, 16'h0, 2'd0, 1'b0);

    run(4'd0, 16'hBEEF, 3'd0, 16'h0, 2'd0, 1'b0);
    run(4'd1, 16'h0040, 3'd0, 16'h0, 2'd0, 1'b0);
    for (int l = 0; l < 4; l++) run(4'd2, 16'h0100 + 16'(l), 3'd1, 16'h0, 2'(l), 1'b0);
    run(4'd4, 16'h0, 3'd2, 16'h0, 2'd0, 1'b0);

    load_reg(3'd6, 16'h0030);
    run(4'd5, 16'hFFF0, 3'd6, 16'h0, 2'd0, 1'b0);
    run(4'd6, 16'hFFF0, 3'd0, 16'h0020, 2'd0, 1'b0);

    load_reg(3'd7, 16'hFFFE);
    run(4'd7, 16'h0010, 3'd7, 16'h0, 2'd0, 1'b0);
    run(4'd7, 16'h0010, 3'd7, 16'h0, 2'd0, 1'b0);
    run(4'd3, 16'h0, 3'd7, 16'h0, 2'd0, 1'b0);
    check(operand == 16'h0000, "R7 increment wraps", operand, 16'h0000);

    run(4'd8, 16'h0200, 3'd3, 16'h0, 2'd0, 1'b0);
    run(4'd9, 16'h0300, 3'd4, 16'h0, 2'd0, 1'b0);
    run(4'd10, 16'h5555, 3'd0, 16'h0, 2'd0, 1'b0);
    run(4'd15, 16'hAAAA, 3'd0, 16'h0, 2'd0, 1'b0);

    run(4'd2, 16'h0777, 3'd2, 16'h0, 2'd3, 1'b1);
    run(4'd3, 16'h0, 3'd2, 16'h0, 2'd0, 1'b0);
    check(operand == rf_m[2], "R13 busy write dropped", operand, rf_m[2]);

    for (int i = 0; i < 300; i++) begin
      if (i % 50 == 0) load_reg(3'($urandom), 16'($urandom));
      run(4'($urandom), 16'($urandom), 3'($urandom), 16'($urandom), 2'($urandom), 1'b0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule